// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address. It does this by walking a tree of descriptors held in memory. A walk begins at a context table entry that is located from a context pointer and a context number. The walk then descends through three directory levels, indexed by successive slices of the virtual address, and stops at a page table entry. Each descriptor is fetched through a word-read port with a simple request and response handshake. Only one read is outstanding at any time.

A finished walk ends with a one-cycle completion pulse. On success the block presents the final page table entry and the physical address formed from it. On failure it presents a fault code that records two things: the level at which the walk stopped and the kind of fault. An access index is also presented on every walk, whether it succeeds or faults. It encodes write, instruction fetch and supervisor mode, and it is captured when the walk is accepted. Permission checks, write-back of referenced or modified bits, and translation caching belong to other blocks.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is held and right after it, `mem_req`, `done`, `fault` and `busy` are all low.
- R2: The first read of a walk goes to the address (ctx_ptr << 4) + (ctx_num << 4), computed 36 bits wide.
- R3: `mem_req` is a one-cycle pulse. No further read is issued until a response for the current read has arrived.
- R4: The low two bits of a descriptor select its kind: 0 invalid, 1 directory, 2 page entry, 3 reserved. After a directory entry at level k, the next read goes to ((desc & ~3) << 4) + 4*index. The index is vaddr[31:24] for level 1, vaddr[23:18] for level 2 and vaddr[17:12] for level 3.
- R5: A page entry returned at level 3 completes the walk without a fault. `pte_out` then equals the entry, and `phys_addr` equals {entry[31:8], vaddr[11:0]}.
- R6: An invalid descriptor ends the walk with a fault. The fault code has the level (0 context, 1, 2, 3) in bits 9:8, the value 1 in bits 4:2, and all other bits zero.
- R7: A reserved descriptor, a page entry found at levels 0 to 2, or a directory entry found at level 3 ends the walk with a fault. Its code has the level in bits 9:8 and the value 4 in bits 4:2.
- R8: `access_idx` equals {is_write, is_fetch, is_super} as sampled with the accepted `start`. It is visible from the next cycle and is valid after faults as well.
- R9: `done` is high for exactly one cycle per walk, and `fault` is high only together with `done`. Results hold until the next accepted `start`.
- R10: A `start` that arrives while a walk is under way is ignored, as is any change of `vaddr` after acceptance. A response that arrives while no read is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; accepted only when idle |
| ctx_ptr | input | 32 | Context table pointer |
| ctx_num | input | 8 | Context number |
| vaddr | input | 32 | Virtual address to translate |
| is_write | input | 1 | Access is a write |
| is_fetch | input | 1 | Access is an instruction fetch |
| is_super | input | 1 | Access is made in supervisor mode |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 36 | Read address, held until the next request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Returned descriptor |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault (valid with done) |
| fault_code | output | 10 | Level in 9:8, fault type in 4:2 |
| access_idx | output | 3 | {write, fetch, supervisor} of the walk |
| pte_out | output | 32 | Final page table entry |
| phys_addr | output | 36 | Translated physical address |

## Verification
The embedded assertions check properties that must hold on every cycle:
- read requests are single-cycle pulses issued only during a walk;
- completion is a single-cycle pulse, and a fault is never flagged without it;
- fault codes contain only the two legal types and no stray bits;
- results and the access index stay stable while the block is idle or walking;
- a start seen during a walk never causes a read by itself.

Some behaviour can only be shown by the bench scenarios, because checking it needs the descriptor contents:
- the exact read address at each level;
- the level recorded for each kind of misplaced or invalid descriptor;
- the physical address built from the final entry;
- the latching of the virtual address against later changes at the input.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_CTX, ST_L1, ST_L2, ST_L3, ST_DONE, ST_FAULT
   } walk_state_e;

   typedef enum logic [1:0] {
      ET_INVALID = 2'd0,
      ET_DIR     = 2'd1,
      ET_PAGE    = 2'd2,
      ET_RSVD    = 2'd3
   } entry_kind_e;

   localparam logic [2:0] FT_INVALID = 3'd1;
   localparam logic [2:0] FT_XLATE   = 3'd4;
   localparam int         LVL_W      = 2;
   localparam int         FCODE_W    = 10;

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
   parameter int VA_W      = 32,
   parameter int DESC_W    = 32,
   parameter int CTX_W     = 8,
   parameter int PA_W      = 36,
   parameter int PAGE_BITS = 12,
   parameter int L1_BITS   = 8,
   parameter int L2_BITS   = 6,
   parameter int L3_BITS   = 6
) (
   input  logic [1:0]        level,
   input  logic [DESC_W-1:0] ctx_ptr,
   input  logic [CTX_W-1:0]  ctx_num,
   input  logic [VA_W-1:0]   walk_va,
   input  logic [DESC_W-1:0] desc,
   output logic [PA_W-1:0]   rd_addr
);
   localparam int L3_LO = PAGE_BITS;
   localparam int L2_LO = L3_LO + L3_BITS;
   localparam int L1_LO = L2_LO + L2_BITS;

   if (L1_LO + L1_BITS != VA_W) begin : g_bad_split
      $error("pgwalk_addr: index fields do not tile the virtual address");
   end
   if (PA_W < DESC_W + 4) begin : g_bad_pa
      $error("pgwalk_addr: physical width too small for table base");
   end

   logic [PA_W-1:0] idx_off [4];
   logic [PA_W-1:0] ctx_addr;
   logic [PA_W-1:0] tbl_base;
   logic            unused_page_bits;

   assign idx_off[0] = '0;
   for (genvar g = 1; g <= 3; g++) begin : g_lvl
      localparam int LO   = (g == 1) ? L1_LO   : (g == 2) ? L2_LO   : L3_LO;
      localparam int BITS = (g == 1) ? L1_BITS : (g == 2) ? L2_BITS : L3_BITS;
      assign idx_off[g] = PA_W'(walk_va[LO +: BITS]) << 2;
   end

   assign unused_page_bits = ^walk_va[PAGE_BITS-1:0];
   assign ctx_addr = (PA_W'(ctx_ptr) << 4) + (PA_W'(ctx_num) << 4);
   assign tbl_base = PA_W'(desc & ~DESC_W'(3)) << 4;

   always_comb begin
      if (level == 2'd0) rd_addr = ctx_addr;
      else               rd_addr = tbl_base + idx_off[level];
   end
endmodule

// File: rtl/pgwalk_classify.sv
module pgwalk_classify
   import pgwalk_pkg::*;
(
   input  logic [1:0] level,
   input  logic [1:0] kind_bits,
   output logic       descend,
   output logic       leaf,
   output logic       bad,
   output logic [2:0] ftype
);
   entry_kind_e kind;
   assign kind = entry_kind_e'(kind_bits);

   always_comb begin
      descend = 1'b0;
      leaf    = 1'b0;
      bad     = 1'b0;
      ftype   = 3'd0;
      unique case (kind)
         ET_INVALID: begin bad = 1'b1; ftype = FT_INVALID; end
         ET_DIR: begin
            if (level == 2'd3) begin bad = 1'b1; ftype = FT_XLATE; end
            else descend = 1'b1;
         end
         ET_PAGE: begin
            if (level == 2'd3) leaf = 1'b1;
            else begin bad = 1'b1; ftype = FT_XLATE; end
         end
         ET_RSVD: begin bad = 1'b1; ftype = FT_XLATE; end
      endcase
   end
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
   import pgwalk_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int DESC_W    = 32,
   parameter int PA_W      = 36,
   parameter int PAGE_BITS = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [VA_W-1:0]    vaddr,
   input  logic               is_write,
   input  logic               is_fetch,
   input  logic               is_super,
   input  logic               rsp_valid,
   input  logic [DESC_W-1:0]  rsp_data,
   input  logic [PA_W-1:0]    next_addr,
   input  logic               descend,
   input  logic               leaf,
   input  logic [2:0]         ftype,
   output logic [1:0]         cur_lvl,
   output logic [1:0]         nxt_lvl,
   output logic [VA_W-1:0]    walk_va,
   output logic               mem_req,
   output logic [PA_W-1:0]    mem_addr,
   output logic               busy,
   output logic               done,
   output logic               fault,
   output logic [FCODE_W-1:0] fault_code,
   output logic [2:0]         access_idx,
   output logic [DESC_W-1:0]  pte_out,
   output logic [PA_W-1:0]    phys_addr
);
   localparam int PPN_W = PA_W - PAGE_BITS;

   if (PPN_W != DESC_W - 8) begin : g_bad_ppn
      $error("pgwalk_fsm: physical width must hold entry[31:8] plus page offset");
   end

   walk_state_e state;

   always_comb begin
      unique case (state)
         ST_CTX:  begin cur_lvl = 2'd0; nxt_lvl = 2'd1; end
         ST_L1:   begin cur_lvl = 2'd1; nxt_lvl = 2'd2; end
         ST_L2:   begin cur_lvl = 2'd2; nxt_lvl = 2'd3; end
         ST_L3:   begin cur_lvl = 2'd3; nxt_lvl = 2'd3; end
         default: begin cur_lvl = 2'd0; nxt_lvl = 2'd0; end
      endcase
   end

   assign busy  = (state == ST_CTX) || (state == ST_L1) ||
                  (state == ST_L2)  || (state == ST_L3);
   assign done  = (state == ST_DONE) || (state == ST_FAULT);
   assign fault = (state == ST_FAULT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         mem_req    <= 1'b0;
         mem_addr   <= '0;
         walk_va    <= '0;
         access_idx <= '0;
         fault_code <= '0;
         pte_out    <= '0;
         phys_addr  <= '0;
      end else begin
         mem_req <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  walk_va    <= vaddr;
                  access_idx <= {is_write, is_fetch, is_super};
                  fault_code <= '0;
                  pte_out    <= '0;
                  phys_addr  <= '0;
                  mem_addr   <= next_addr;
                  mem_req    <= 1'b1;
                  state      <= ST_CTX;
               end
            end
            ST_CTX, ST_L1, ST_L2, ST_L3: begin
               if (rsp_valid) begin
                  if (descend) begin
                     mem_addr <= next_addr;
                     mem_req  <= 1'b1;
                     unique case (state)
                        ST_CTX:  state <= ST_L1;
                        ST_L1:   state <= ST_L2;
                        default: state <= ST_L3;
                     endcase
                  end else if (leaf) begin
                     pte_out   <= rsp_data;
                     phys_addr <= {rsp_data[DESC_W-1 -: PPN_W], walk_va[PAGE_BITS-1:0]};
                     state     <= ST_DONE;
                  end else begin
                     fault_code <= {cur_lvl, 3'b000, ftype, 2'b00};
                     state      <= ST_FAULT;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   assert_req_in_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_fault_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);
   assert_fault_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> ((fault_code[4:2] == FT_INVALID) || (fault_code[4:2] == FT_XLATE)) &&
                (fault_code[7:5] == 3'b000) && (fault_code[1:0] == 2'b00));
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !start) |=> $stable(fault_code) && $stable(phys_addr) &&
                                       $stable(pte_out) && $stable(access_idx));
   assert_acc_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(access_idx));
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !rsp_valid) |=> !mem_req);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
   parameter int VA_W      = 32,
   parameter int DESC_W    = 32,
   parameter int CTX_W     = 8,
   parameter int PA_W      = 36,
   parameter int PAGE_BITS = 12,
   parameter int L1_BITS   = 8,
   parameter int L2_BITS   = 6,
   parameter int L3_BITS   = 6,
   localparam int FC_W     = pgwalk_pkg::FCODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DESC_W-1:0] ctx_ptr,
   input  logic [CTX_W-1:0]  ctx_num,
   input  logic [VA_W-1:0]   vaddr,
   input  logic              is_write,
   input  logic              is_fetch,
   input  logic              is_super,
   output logic              mem_req,
   output logic [PA_W-1:0]   mem_addr,
   input  logic              mem_rsp_valid,
   input  logic [DESC_W-1:0] mem_rsp_data,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [FC_W-1:0]   fault_code,
   output logic [2:0]        access_idx,
   output logic [DESC_W-1:0] pte_out,
   output logic [PA_W-1:0]   phys_addr
);
   logic [1:0]      cur_lvl;
   logic [1:0]      nxt_lvl;
   logic [VA_W-1:0] walk_va;
   logic [PA_W-1:0] next_addr;
   logic            descend;
   logic            leaf;
   logic            bad;
   logic [2:0]      ftype;
   logic            unused_bad;

   assign unused_bad = bad;

   pgwalk_addr #(
      .VA_W(VA_W), .DESC_W(DESC_W), .CTX_W(CTX_W), .PA_W(PA_W),
      .PAGE_BITS(PAGE_BITS), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .L3_BITS(L3_BITS)
   ) u_addr (
      .level(nxt_lvl), .ctx_ptr(ctx_ptr), .ctx_num(ctx_num),
      .walk_va(walk_va), .desc(mem_rsp_data), .rd_addr(next_addr)
   );

   pgwalk_classify u_cls (
      .level(cur_lvl), .kind_bits(mem_rsp_data[1:0]),
      .descend(descend), .leaf(leaf), .bad(bad), .ftype(ftype)
   );

   pgwalk_fsm #(
      .VA_W(VA_W), .DESC_W(DESC_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
      .is_write(is_write), .is_fetch(is_fetch), .is_super(is_super),
      .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data), .next_addr(next_addr),
      .descend(descend), .leaf(leaf), .ftype(ftype),
      .cur_lvl(cur_lvl), .nxt_lvl(nxt_lvl), .walk_va(walk_va),
      .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy), .done(done),
      .fault(fault), .fault_code(fault_code), .access_idx(access_idx),
      .pte_out(pte_out), .phys_addr(phys_addr)
   );

   assert_single_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_rsp_valid) |-> $onehot({descend, leaf, bad}));
endmodule

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;

   typedef struct packed {
      logic [31:0] cp;
      logic [7:0]  cn;
      logic [31:0] va;
      logic [2:0]  acc;
      logic [31:0] d0, d1, d2, d3;
      logic [1:0]  last;
      logic        flt;
      logic [9:0]  code;
   } vec_t;

   localparam vec_t TBL [NV] = '{
      '{32'h0000_1000, 8'h02, 32'h1234_5ABC, 3'b001, 32'h0000_2001, 32'h0000_3001, 32'h0000_4001, 32'h1234_5602, 2'd3, 1'b0, 10'h000},
      '{32'h0000_2000, 8'h10, 32'hFFFF_F123, 3'b100, 32'h0000_0000, 32'h0,         32'h0,         32'h0,         2'd0, 1'b1, 10'h004},
      '{32'h0000_0000, 8'hFF, 32'h0000_0000, 3'b010, 32'h0000_5002, 32'h0,         32'h0,         32'h0,         2'd0, 1'b1, 10'h010},
      '{32'h0000_1234, 8'h01, 32'h8040_3000, 3'b011, 32'h0000_7001, 32'h0000_7101, 32'h0000_0004, 32'h0,         2'd2, 1'b1, 10'h204},
      '{32'h0000_0010, 8'h00, 32'h0100_0000, 3'b110, 32'h0000_8001, 32'hFFFF_FFFF, 32'h0,         32'h0,         2'd1, 1'b1, 10'h110},
      '{32'h0000_0ABC, 8'h07, 32'h00FF_F000, 3'b101, 32'h0000_0101, 32'h0000_0201, 32'h0000_0301, 32'h0000_0401, 2'd3, 1'b1, 10'h310},
      '{32'h0000_4000, 8'h03, 32'h5555_5555, 3'b000, 32'h0000_9001, 32'h0000_9101, 32'hDEAD_BE02, 32'h0,         2'd2, 1'b1, 10'h210},
      '{32'h0FFF_FFFF, 8'h80, 32'hFFFF_FFFF, 3'b111, 32'hFFFF_FFFD, 32'h0000_0001, 32'hAAAA_AAA9, 32'hFFFF_FF06, 2'd3, 1'b0, 10'h000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] ctx_ptr = '0;
   logic [7:0]  ctx_num = '0;
   logic [31:0] vaddr = '0;
   logic        is_write = 1'b0, is_fetch = 1'b0, is_super = 1'b0;
   logic        mem_req;
   logic [35:0] mem_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        busy, done, fault;
   logic [9:0]  fault_code;
   logic [2:0]  access_idx;
   logic [31:0] pte_out;
   logic [35:0] phys_addr;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgwalk_top uut (
      .clk(clk), .rst_n(rst_n), .start(start), .ctx_ptr(ctx_ptr), .ctx_num(ctx_num),
      .vaddr(vaddr), .is_write(is_write), .is_fetch(is_fetch), .is_super(is_super),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done), .fault(fault),
      .fault_code(fault_code), .access_idx(access_idx), .pte_out(pte_out),
      .phys_addr(phys_addr)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [35:0] exp_addr(input vec_t v, input int k);
      logic [31:0] d;
      logic [35:0] base;
      d = (k == 1) ? v.d0 : (k == 2) ? v.d1 : v.d2;
      base = {d[31:2], 6'b0};
      case (k)
         0:       return ({4'b0, v.cp} << 4) + ({28'b0, v.cn} << 4);
         1:       return base + {26'b0, v.va[31:24], 2'b00};
         2:       return base + {28'b0, v.va[23:18], 2'b00};
         default: return base + {28'b0, v.va[17:12], 2'b00};
      endcase
   endfunction

   task automatic run_vec(input vec_t v, input bit poke);
      int last = -1;
      logic [31:0] dk;
      @(negedge clk);
      ctx_ptr = v.cp; ctx_num = v.cn; vaddr = v.va;
      {is_write, is_fetch, is_super} = v.acc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8", "access index", 64'(access_idx), 64'(v.acc));
      for (int k = 0; k < 4; k++) begin
         for (int t = 0; t < 20 && !mem_req && !done; t++) @(negedge clk);
         if (done || !mem_req) break;
         chk(k == 0 ? "R2" : "R4", $sformatf("read address level %0d", k),
             64'(mem_addr), 64'(exp_addr(v, k)));
         @(negedge clk);
         chk("R3", "request is one cycle", 64'(mem_req), 64'd0);
         if (poke && k == 0) begin
            start = 1'b1;
            vaddr = ~v.va;
         end
         @(negedge clk);
         if (poke && k == 0)
            chk("R10", "start during walk gives no read", 64'(mem_req), 64'd0);
         start = 1'b0;
         dk = (k == 0) ? v.d0 : (k == 1) ? v.d1 : (k == 2) ? v.d2 : v.d3;
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = dk;
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         last = k;
      end
      for (int t = 0; t < 20 && !done; t++) @(negedge clk);
      chk("R9", "done pulse", 64'(done), 64'd1);
      chk("R4", "levels read", 64'(last), 64'(v.last));
      chk(v.flt ? (v.code[4:2] == 3'd1 ? "R6" : "R7") : "R5", "fault flag",
          64'(fault), 64'(v.flt));
      chk(v.flt ? (v.code[4:2] == 3'd1 ? "R6" : "R7") : "R5", "fault code",
          64'(fault_code), 64'(v.code));
      chk("R8", "access index at end", 64'(access_idx), 64'(v.acc));
      if (!v.flt) begin
         chk("R5", "pte", 64'(pte_out), 64'(v.d3));
         chk("R5", "physical address", 64'(phys_addr), 64'({v.d3[31:8], v.va[11:0]}));
      end
      @(negedge clk);
      chk("R9", "done falls", 64'(done), 64'd0);
      @(negedge clk);
      @(negedge clk);
      chk("R9", "code held", 64'(fault_code), 64'(v.code));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "req in reset", 64'(mem_req), 64'd0);
      chk("R1", "done in reset", 64'(done), 64'd0);
      chk("R1", "busy in reset", 64'(busy), 64'd0);
      chk("R1", "fault in reset", 64'(fault), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "idle after reset", 64'({mem_req, done, busy}), 64'd0);

      for (int i = 0; i < NV; i++) run_vec(TBL[i], 1'b0);

      // R10: start and vaddr changes during the walk are ignored
      run_vec(TBL[0], 1'b1);

      // R10: a response with no pending read is ignored
      @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'h0000_0000;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R10", "stray response no done", 64'(done), 64'd0);
      chk("R10", "stray response no read", 64'(mem_req), 64'd0);
      chk("R10", "stray response idle", 64'(busy), 64'd0);
      @(negedge clk);
      chk("R10", "stray response keeps result", 64'(phys_addr),
          64'({TBL[0].d3[31:8], TBL[0].va[11:0]}));

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule